// File: doc/BRIEF.md
# Partial-Flag Threshold Offset Registers

This block stores the two threshold offsets of a synchronous FIFO. One sets how close to empty the almost-empty flag trips. The other sets how close to full the almost-full flag trips. Comparators elsewhere in the FIFO use both values.

The level of the active-low load pin while master reset is asserted chooses the start-up value of both offsets. It also chooses the one loading method that software may use afterwards. A low level selects parallel loading with small defaults. A high level selects serial loading with large defaults. Only another master reset can change that choice.

- **Parallel loading:** the two registers are written in turn from the data input, under a dedicated write pointer.
- **Serial loading:** one bit enters per write-clock edge into a single chain that spans both registers.
- **Readback:** always parallel, in the read-clock domain, under a dedicated read pointer. It works in either mode.

Top module: `pflag_offset_regs`

## Requirements
- R1: The loading method is latched from `load_n` on every write-clock edge where `mrst` is high. Toggling `load_n` at any other time does not change which method is accepted.
- R2: A master reset with `load_n`=0 sets both offsets to 127 (0x07F) and selects parallel loading.
- R3: A master reset with `load_n`=1 sets both offsets to 1023 (0x3FF) and selects serial loading.
- R4: In serial mode, each write-clock edge with `load_n`=0 and `sen_n`=0 shifts `sdata` into a 26-bit chain made of {full offset, empty offset}. The first bit shifted lands after 26 shifts in bit 0 of the empty offset, and the last bit lands in bit 12 of the full offset.
- R5: In serial mode, a write-clock edge with `sen_n`=1 leaves both offsets unchanged. A serial load split by such idle cycles gives the same result as an unbroken one.
- R6: In parallel mode, each write-clock edge with `load_n`=0 and `wen_n`=0 stores `din[12:0]` into the register the write pointer selects. The first write goes to the empty offset, the next to the full offset.
- R7: Each read-clock edge with `load_n`=0 and `ren_n`=0 puts the offset the read pointer selects on `dout[12:0]`, empty offset first, with `dout[17:13]`=0. `dout` is 0 after master reset and otherwise holds its last value.
- R8: Offset readback works the same way in serial mode as in parallel mode.
- R9: With `load_n`=1, `wen_n` and `ren_n` leave the offsets, the pointers and `dout` unchanged.
- R10: Parallel writes are ignored in serial mode, and serial shifts are ignored in parallel mode.
- R11: After accessing the full offset, each pointer returns to the empty offset. Master reset points both pointers at the empty offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Synchronous active-high master reset, seen in both clock domains |
| load_n | input | 1 | Active-low load: selects offset access; its level during reset picks mode and defaults |
| wen_n | input | 1 | Active-low write enable (parallel offset write when load_n=0) |
| sen_n | input | 1 | Active-low serial shift enable |
| sdata | input | 1 | Serial offset data |
| din | input | 18 | Parallel data input; bits 12:0 carry the offset |
| ren_n | input | 1 | Active-low read enable (offset readback when load_n=0) |
| dout | output | 18 | Offset readback output, upper bits zero |

## Verification
A wrong write pointer shows up as the wrong register holding a written value. The next two-read readback exposes it, one read-clock edge per register. A stuck or wrongly latched mode shows as a rejected write, or as a write accepted by the wrong method, on the next readback. A misordered serial chain shows bit-swapped values once a 26-bit load is read back. A read pointer that fails to advance or wrap repeats or skips a register on `dout` in the cycle after the read edge.

// File: rtl/pflag_ofs_pkg.sv
package pflag_ofs_pkg;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_e;

    // Pointer step: empty -> full -> empty
    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/pflag_ofs_wr_ctrl.sv
module pflag_ofs_wr_ctrl
    import pflag_ofs_pkg::*;
(
    input  logic       clk,
    input  logic       mrst,
    input  logic       load_n,
    input  logic       wen_n,
    input  logic       sen_n,
    output load_mode_e mode,
    output logic       shift_en,
    output logic       wr_empty,
    output logic       wr_full
);

    ofs_sel_e wptr;
    logic     par_wr;

    always_comb begin
        par_wr   = !mrst && !load_n && !wen_n && (mode == LOAD_PARALLEL);
        shift_en = !mrst && !load_n && !sen_n && (mode == LOAD_SERIAL);
        wr_empty = par_wr && (wptr == SEL_EMPTY);
        wr_full  = par_wr && (wptr == SEL_FULL);
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            mode <= load_n ? LOAD_SERIAL : LOAD_PARALLEL;
            wptr <= SEL_EMPTY;
        end else if (par_wr) begin
            wptr <= next_sel(wptr);
        end
    end

endmodule

// File: rtl/pflag_ofs_store.sv
module pflag_ofs_store #(
    parameter int OFF_W  = 13,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             load_n,
    input  logic             shift_en,
    input  logic             wr_empty,
    input  logic             wr_full,
    input  logic             sdata,
    input  logic [OFF_W-1:0] wdata,
    output logic [OFF_W-1:0] empty_ofs,
    output logic [OFF_W-1:0] full_ofs
);

    localparam int CHAIN_W = 2 * OFF_W;

    logic [CHAIN_W-1:0] chain_cur;
    logic [CHAIN_W-1:0] chain_nxt;

    always_comb begin
        chain_cur = {full_ofs, empty_ofs};
        chain_nxt = {sdata, chain_cur[CHAIN_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            empty_ofs <= load_n ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO);
            full_ofs  <= load_n ? OFF_W'(DEF_HI) : OFF_W'(DEF_LO);
        end else if (shift_en) begin
            full_ofs  <= chain_nxt[CHAIN_W-1:OFF_W];
            empty_ofs <= chain_nxt[OFF_W-1:0];
        end else begin
            if (wr_empty) empty_ofs <= wdata;
            if (wr_full)  full_ofs  <= wdata;
        end
    end

endmodule

// File: rtl/pflag_ofs_readback.sv
module pflag_ofs_readback
    import pflag_ofs_pkg::*;
#(
    parameter int OFF_W  = 13,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              load_n,
    input  logic              ren_n,
    input  logic [OFF_W-1:0]  empty_ofs,
    input  logic [OFF_W-1:0]  full_ofs,
    output ofs_sel_e          rptr,
    output logic [DATA_W-1:0] dout
);

    localparam int PAD_W = DATA_W - OFF_W;

    logic             rd;
    logic [OFF_W-1:0] sel_val;

    always_comb begin
        rd      = !load_n && !ren_n;
        sel_val = (rptr == SEL_FULL) ? full_ofs : empty_ofs;
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            rptr <= SEL_EMPTY;
            dout <= '0;
        end else if (rd) begin
            rptr <= next_sel(rptr);
            dout <= {{PAD_W{1'b0}}, sel_val};
        end
    end

endmodule

// File: rtl/pflag_offset_regs.sv
module pflag_offset_regs
    import pflag_ofs_pkg::*;
#(
    parameter int OFF_W  = 13,
    parameter int DATA_W = 18,
    parameter int DEF_LO = 127,
    parameter int DEF_HI = 1023
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic              load_n,
    input  logic              wen_n,
    input  logic              sen_n,
    input  logic              sdata,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_n,
    output logic [DATA_W-1:0] dout
);

    load_mode_e       mode;
    ofs_sel_e         rptr;
    logic             shift_en;
    logic             wr_empty;
    logic             wr_full;
    logic [OFF_W-1:0] empty_ofs;
    logic [OFF_W-1:0] full_ofs;

    pflag_ofs_wr_ctrl u_wr_ctrl (
        .clk      (wclk),
        .mrst     (mrst),
        .load_n   (load_n),
        .wen_n    (wen_n),
        .sen_n    (sen_n),
        .mode     (mode),
        .shift_en (shift_en),
        .wr_empty (wr_empty),
        .wr_full  (wr_full)
    );

    pflag_ofs_store #(
        .OFF_W  (OFF_W),
        .DEF_LO (DEF_LO),
        .DEF_HI (DEF_HI)
    ) u_store (
        .clk       (wclk),
        .mrst      (mrst),
        .load_n    (load_n),
        .shift_en  (shift_en),
        .wr_empty  (wr_empty),
        .wr_full   (wr_full),
        .sdata     (sdata),
        .wdata     (din[OFF_W-1:0]),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs)
    );

    pflag_ofs_readback #(
        .OFF_W  (OFF_W),
        .DATA_W (DATA_W)
    ) u_readback (
        .clk       (rclk),
        .mrst      (mrst),
        .load_n    (load_n),
        .ren_n     (ren_n),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rptr      (rptr),
        .dout      (dout)
    );

endmodule

// File: rtl/pflag_offset_regs_chk.sv
module pflag_offset_regs_chk
    import pflag_ofs_pkg::*;
#(
    parameter int OFF_W  = 13,
    parameter int DATA_W = 18
) (
    input logic              wclk,
    input logic              rclk,
    input logic              mrst,
    input logic              load_n,
    input logic              wen_n,
    input logic              sen_n,
    input logic              sdata,
    input logic              ren_n,
    input load_mode_e        mode,
    input ofs_sel_e          rptr,
    input logic [OFF_W-1:0]  empty_ofs,
    input logic [OFF_W-1:0]  full_ofs,
    input logic [DATA_W-1:0] dout
);

    AST_MODE_LOCKED: assert property (@(posedge wclk) disable iff (mrst)
        !mrst |=> $stable(mode)); // R1

    AST_SHIFT_TAIL: assert property (@(posedge wclk) disable iff (mrst)
        (mode == LOAD_SERIAL && !load_n && !sen_n)
        |=> (full_ofs[OFF_W-1] == $past(sdata))); // R4

    AST_SEN_HOLD: assert property (@(posedge wclk) disable iff (mrst)
        (mode == LOAD_SERIAL && sen_n)
        |=> ($stable(empty_ofs) && $stable(full_ofs))); // R5

    AST_LOAD_HIGH_HOLD: assert property (@(posedge wclk) disable iff (mrst)
        load_n |=> ($stable(empty_ofs) && $stable(full_ofs))); // R9

    AST_LOAD_HIGH_DOUT: assert property (@(posedge rclk) disable iff (mrst)
        load_n |=> ($stable(dout) && $stable(rptr))); // R9

    AST_PAR_NO_SHIFT: assert property (@(posedge wclk) disable iff (mrst)
        (mode == LOAD_PARALLEL && wen_n)
        |=> ($stable(empty_ofs) && $stable(full_ofs))); // R10

    AST_RPTR_STEP: assert property (@(posedge rclk) disable iff (mrst)
        (!load_n && !ren_n) |=> (rptr != $past(rptr))); // R11

endmodule

bind pflag_offset_regs pflag_offset_regs_chk #(
    .OFF_W  (OFF_W),
    .DATA_W (DATA_W)
) u_chk (
    .wclk      (wclk),
    .rclk      (rclk),
    .mrst      (mrst),
    .load_n    (load_n),
    .wen_n     (wen_n),
    .sen_n     (sen_n),
    .sdata     (sdata),
    .ren_n     (ren_n),
    .mode      (mode),
    .rptr      (rptr),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .dout      (dout)
);

// File: tb/pflag_offset_regs_bench.sv
`timescale 1ns/1ps
module pflag_offset_regs_bench;

    localparam int OFF_W  = 13;
    localparam int DATA_W = 18;
    localparam int LO_DEF = 127;
    localparam int HI_DEF = 1023;

    logic              clk = 1'b0;
    logic              mrst = 1'b1;
    logic              load_n = 1'b0;
    logic              wen_n = 1'b1;
    logic              sen_n = 1'b1;
    logic              sdata = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic              ren_n = 1'b1;
    logic [DATA_W-1:0] dout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pflag_offset_regs u_pflag_offset_regs (
        .wclk   (clk),
        .rclk   (clk),
        .mrst   (mrst),
        .load_n (load_n),
        .wen_n  (wen_n),
        .sen_n  (sen_n),
        .sdata  (sdata),
        .din    (din),
        .ren_n  (ren_n),
        .dout   (dout)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%05h expected=0x%05h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic ld);
        mrst = 1'b1; load_n = ld; wen_n = 1'b1; sen_n = 1'b1; ren_n = 1'b1;
        tick(); tick();
        mrst = 1'b0; load_n = 1'b1;
    endtask

    task automatic par_write(input logic [DATA_W-1:0] v);
        load_n = 1'b0; wen_n = 1'b0; din = v;
        tick();
        wen_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic ser_bit(input logic b);
        load_n = 1'b0; sen_n = 1'b0; sdata = b;
        tick();
        sen_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic ser_load(input logic [OFF_W-1:0] e, input logic [OFF_W-1:0] f,
                            input int gap_at);
        for (int i = 0; i < 2*OFF_W; i++) begin
            if (i == gap_at) begin
                // idle with serial enable high, data wiggling
                load_n = 1'b0;
                for (int g = 0; g < 3; g++) begin sdata = g[0]; tick(); end
                load_n = 1'b1;
            end
            ser_bit(i < OFF_W ? e[i] : f[i-OFF_W]);
        end
    endtask

    task automatic read_ofs(output logic [DATA_W-1:0] v);
        load_n = 1'b0; ren_n = 1'b0;
        tick();
        v = dout;
        ren_n = 1'b1; load_n = 1'b1;
    endtask

    task automatic expect_pair(input string req, input int e, input int f);
        logic [DATA_W-1:0] v;
        read_ofs(v); chk(req, v, DATA_W'(e));
        read_ofs(v); chk(req, v, DATA_W'(f));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] held;
        @(negedge clk);

        // R2 defaults, R7 reset value of dout
        do_reset(1'b0);
        chk("R7 dout after reset", dout, '0);
        expect_pair("R2 low-load defaults", LO_DEF, LO_DEF);
        // R11 read pointer wraps: third read is empty again
        par_write(18'h00011); par_write(18'h00022);
        read_ofs(v); chk("R11 rptr wrap empty", v, 18'h00011);
        read_ofs(v); chk("R11 rptr wrap full", v, 18'h00022);
        read_ofs(v); chk("R11 rptr wrap back to empty", v, 18'h00011);
        read_ofs(v); // realign pointer to empty

        // R6/R7 parallel sweep with garbage upper din bits
        for (int k = 0; k < 16; k++) begin
            int a = (k * 733 + 5) & 16'h1FFF;
            int b = ((k * 1291) ^ 16'h1555) & 16'h1FFF;
            par_write({5'(k ^ 5'h15), 13'(a)});
            par_write({5'(~k), 13'(b)});
            expect_pair("R6 parallel write / R7 readback", a, b);
        end

        // R11 write pointer wraps after full
        par_write(18'h00101); par_write(18'h00202); par_write(18'h00303);
        expect_pair("R11 wptr wrap", 18'h00303, 18'h00202);
        par_write(18'h00404); // pointer now at empty again after this? (third+fourth)
        expect_pair("R11 wptr wrap second", 18'h00303, 18'h00404);

        // R10 serial shift ignored in parallel mode; R1 load toggle keeps mode
        load_n = 1'b1; tick(); load_n = 1'b0; tick(); load_n = 1'b1; tick();
        for (int i = 0; i < 2*OFF_W; i++) ser_bit(1'b1);
        expect_pair("R10/R1 serial ignored in parallel mode", 18'h00303, 18'h00404);

        // R9 load high: wen/ren do nothing
        load_n = 1'b1; wen_n = 1'b0; din = 18'h01ABC;
        tick(); tick(); tick();
        wen_n = 1'b1;
        read_ofs(v); read_ofs(held); // rptr back at empty, dout = full value
        load_n = 1'b1; ren_n = 1'b0; tick(); tick(); ren_n = 1'b1;
        chk("R9 dout held with load high", dout, held);
        expect_pair("R9 offsets unchanged and rptr unmoved", 18'h00303, 18'h00404);

        // R11 reset clears pointers
        par_write(18'h00555);           // wptr now at full
        read_ofs(v);                    // rptr now at full
        do_reset(1'b0);
        par_write(18'h00777);
        expect_pair("R11 pointers cleared by reset", 18'h00777, LO_DEF);

        // R3 serial mode defaults, R8 readback works
        do_reset(1'b1);
        expect_pair("R3/R8 high-load defaults", HI_DEF, HI_DEF);

        // R4 serial sweep; R5 gaps mid-load
        for (int k = 0; k < 8; k++) begin
            int e = (k * 1877 + 3) & 16'h1FFF;
            int f = ((k * 3001) ^ 16'h0A5A) & 16'h1FFF;
            ser_load(13'(e), 13'(f), (k % 2 == 0) ? 99 : 4 + 3 * k);
            expect_pair("R4/R5 serial load order", e, f);
        end
        // single-bit ordering: only the first bit set lands in empty bit 0
        ser_load(13'h0001, 13'h0000, 99);
        expect_pair("R4 first bit to empty lsb", 1, 0);
        ser_load(13'h0000, 13'h1000, 99);
        expect_pair("R4 last bit to full msb", 0, 18'h01000);

        // R5 sen_n high holds even with load low and data toggling
        load_n = 1'b0; sen_n = 1'b1;
        for (int g = 0; g < 5; g++) begin sdata = g[0]; tick(); end
        load_n = 1'b1;
        expect_pair("R5 hold with serial enable high", 0, 18'h01000);

        // R10 parallel write ignored in serial mode; R1 mode persists
        load_n = 1'b0; tick(); load_n = 1'b1; tick();
        par_write(18'h00123); par_write(18'h00456);
        expect_pair("R10/R1 parallel ignored in serial mode", 0, 18'h01000);

        // R1 re-reset low returns to parallel
        do_reset(1'b0);
        par_write(18'h00ACE); par_write(18'h00BDF);
        expect_pair("R1 mode re-latched at reset", 18'h00ACE, 18'h00BDF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule